// File: doc/BRIEF.md
# ZVS Full-Bridge PWM Steering Generator

This block produces the four gate commands of a zero-voltage-switching full bridge from a digital timebase. The timebase runs in oscillator periods. Each period has a charge phase of `chg_len` cycles, which is the window in which a lower switch may conduct. A dead phase of `dead_len` cycles follows it. Two oscillator periods make one bridge switching cycle. The upper pair runs at a fixed 50% duty, complementary, and changes state once per period inside the dead phase. The lower pair takes turns, one pulse per period, and its trailing edge is modulated by the duty code.

The resonant-delay fraction places the upper transition a programmable share of the dead time ahead of the next lower turn-on. This gives the bridge node time to swing before the lower switch closes. A digital overcurrent flag cuts the active lower pulse at once, except during a leading-edge blanking window after turn-on. The cut lasts only for the current period. A fault input forces every output low and restarts the timebase. The duty code and the fraction are control pins, not streams: they are read at period boundaries and there is no handshake. `chg_len` and `dead_len` are configuration values. They are changed only while reset or fault is asserted, and each must be at least 1.

Top module: `zvs_bridge_pwm`

## Requirements
- R1: While reset is asserted, out_ul=0, out_ur=1 and both lower outputs are 0. After release the block sits in a dead phase of dead_len cycles before the first period begins.
- R2: Each period is chg_len charge cycles followed by dead_len dead cycles. A lower output can be high only during charge cycles. Period 0, 2, 4, ... drives out_lr and period 1, 3, ... drives out_ll.
- R3: With the default zero-duty level 4, the lower pulse starts in charge cycle 0 and lasts min(duty_code - 4, chg_len) cycles. A duty_code of 4 or less gives no lower pulse, and the upper pair keeps toggling.
- R4: out_ul and out_ur are complementary outside fault. Each changes exactly once per period, so each has 50% duty over a switching cycle.
- R5: With F = min(resdel_frac, 16), the resonant delay is floor(dead_len*F/16) cycles. The upper pair changes that many cycles before the next charge cycle 0, and in that cycle both lower outputs are 0.
- R6: When ovc_flag is high during charge cycle j >= 7 (the default blanking length), the active lower output is low in that same cycle. When ovc_flag is high during charge cycles 0..6, it has no effect.
- R7: Once a pulse has been cut by overcurrent, it stays off for the rest of that period even after ovc_flag drops. The next period pulses normally.
- R8: The steering alternates every period, whether the pulse was full, cut short or skipped. The same lower output never pulses in two consecutive periods.
- R9: While fault is high, all four outputs are 0 in the same cycle. After fault drops, the block restarts exactly as after reset release.
- R10: duty_code and resdel_frac are sampled in the cycle before charge cycle 0. A change after that point takes effect in the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chg_len | input | 8 | Charge-phase length in cycles (at least 1) |
| dead_len | input | 8 | Dead-phase length in cycles (at least 1) |
| duty_code | input | 8 | Error/duty code, compared against the charge cycle index |
| resdel_frac | input | 5 | Resonant-delay fraction in sixteenths of the dead time, clamped at 16 |
| ovc_flag | input | 1 | Overcurrent comparator result |
| fault | input | 1 | Undervoltage or over-temperature fault |
| out_ul | output | 1 | Upper-left switch command |
| out_ur | output | 1 | Upper-right switch command |
| out_ll | output | 1 | Lower-left switch command |
| out_lr | output | 1 | Lower-right switch command |

## Verification
The bench sweeps the duty code across the zero-duty level and past the charge length. A design with an off-by-one in the compare would show pulses one cycle too long, or a sliver at the zero level. It sweeps the fraction from 0 past the clamp, including 100%, where the upper edge coincides with the end of the charge window. A wrong target computation would move the upper edge into a lower pulse, or skip a toggle at a period boundary. Overcurrent is applied at every charge cycle, inside and outside the blanking window, and also held continuously. This catches missing blanking, a cut that waits a cycle, a pulse that revives after the flag drops, and steering that fails to advance after a cut. Finally, a mid-period change of duty and fraction, and a fault in the middle of a pulse, expose sampling at the wrong edge and a restart that keeps stale state.

// File: rtl/zvs_pkg.sv
`timescale 1ns/1ps
package zvs_pkg;
  typedef enum logic {PH_CHG = 1'b0, PH_DEAD = 1'b1} phase_e;
endpackage

// File: rtl/zvs_timebase.sv
`timescale 1ns/1ps
module zvs_timebase
  import zvs_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] chg_len,
  input  logic [CNT_W-1:0] dead_len,
  output phase_e           phase_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             start_nxt_o,
  output logic             dead_nxt_o
);
  logic chg_last, dead_last;

  assign chg_last    = (cnt_o == chg_len - 1'b1);
  assign dead_last   = (cnt_o == dead_len - 1'b1);
  assign dead_nxt_o  = (phase_o == PH_CHG) && chg_last;
  assign start_nxt_o = (phase_o == PH_DEAD) && dead_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_o <= PH_DEAD;
      cnt_o   <= '0;
    end else if (clr) begin
      phase_o <= PH_DEAD;
      cnt_o   <= '0;
    end else if (dead_nxt_o) begin
      phase_o <= PH_DEAD;
      cnt_o   <= '0;
    end else if (start_nxt_o) begin
      phase_o <= PH_CHG;
      cnt_o   <= '0;
    end else begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

  // R2
  period_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_nxt_o && !clr |=> phase_o == PH_CHG && cnt_o == '0);
endmodule

// File: rtl/zvs_upper_steer.sv
`timescale 1ns/1ps
module zvs_upper_steer
  import zvs_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  phase_e           phase_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] dead_len,
  input  logic             start_nxt_i,
  input  logic             dead_nxt_i,
  input  logic [FRAC_W:0]  frac_i,
  output logic             ul_o,
  output logic             rdel_nz_o
);
  localparam int PW = CNT_W + FRAC_W + 1;
  localparam logic [FRAC_W:0] FULL = (FRAC_W+1)'(1) << FRAC_W;

  logic [FRAC_W:0]  frac_s, frac_c;
  logic [PW-1:0]    prod;
  logic [CNT_W-1:0] rdel, tgt;
  logic [CNT_W:0]   cnt_p1;
  logic             toggle;

  assign frac_c    = (frac_i > FULL) ? FULL : frac_i;
  assign prod      = PW'(dead_len) * PW'(frac_s);
  assign rdel      = CNT_W'(prod >> FRAC_W);
  assign tgt       = dead_len - rdel;
  assign cnt_p1    = {1'b0, cnt_i} + 1'b1;
  assign toggle    = ((tgt == '0) && dead_nxt_i) ||
                     ((phase_i == PH_DEAD) && (cnt_p1 == {1'b0, tgt}));
  assign rdel_nz_o = (rdel != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ul_o   <= 1'b0;
      frac_s <= '0;
    end else if (clr) begin
      ul_o   <= 1'b0;
      frac_s <= '0;
    end else begin
      if (start_nxt_i) frac_s <= frac_c;
      if (toggle)      ul_o   <= ~ul_o;
    end
  end

  // R4
  upper_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ul_o != $past(ul_o) |-> phase_i == PH_DEAD || cnt_i == '0);
endmodule

// File: rtl/zvs_lower_mod.sv
`timescale 1ns/1ps
module zvs_lower_mod
  import zvs_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int LEB_CYC   = 7,
  parameter int ZERO_CODE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  phase_e           phase_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             start_nxt_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             ovc_i,
  output logic             ll_o,
  output logic             lr_o
);
  localparam logic [CNT_W-1:0] ZL    = CNT_W'(ZERO_CODE);
  localparam logic [CNT_W-1:0] LEB_L = CNT_W'(LEB_CYC);

  logic             side_r, term_r;
  logic [CNT_W-1:0] width_s, w_c;
  logic             on, blank, kill, pulse;

  assign w_c   = (duty_i > ZL) ? duty_i - ZL : '0;
  assign on    = (phase_i == PH_CHG) && (cnt_i < width_s) && !term_r;
  assign blank = (cnt_i < LEB_L);
  assign kill  = on && ovc_i && !blank;
  assign pulse = on && !kill;
  assign ll_o  = pulse && !side_r;
  assign lr_o  = pulse && side_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      side_r  <= 1'b0;
      term_r  <= 1'b0;
      width_s <= '0;
    end else if (clr) begin
      side_r  <= 1'b0;
      term_r  <= 1'b0;
      width_s <= '0;
    end else if (start_nxt_i) begin
      side_r  <= ~side_r;
      term_r  <= 1'b0;
      width_s <= w_c;
    end else if (kill) begin
      term_r  <= 1'b1;
    end
  end

  // R6
  ovc_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovc_i && phase_i == PH_CHG && cnt_i >= LEB_L |-> !(ll_o || lr_o));
  // R7
  term_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill && !clr && !start_nxt_i |=> !(ll_o || lr_o));
  // R8
  side_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_nxt_i && !clr |=> side_r != $past(side_r));
endmodule

// File: rtl/zvs_bridge_pwm.sv
`timescale 1ns/1ps
module zvs_bridge_pwm
  import zvs_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int FRAC_W    = 4,
  parameter int LEB_CYC   = 7,
  parameter int ZERO_CODE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] chg_len,
  input  logic [CNT_W-1:0] dead_len,
  input  logic [CNT_W-1:0] duty_code,
  input  logic [FRAC_W:0]  resdel_frac,
  input  logic             ovc_flag,
  input  logic             fault,
  output logic             out_ul,
  output logic             out_ur,
  output logic             out_ll,
  output logic             out_lr
);
  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             start_nxt, dead_nxt;
  logic             ul, rdel_nz, ll_raw, lr_raw;

  zvs_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .clr(fault),
    .chg_len(chg_len), .dead_len(dead_len),
    .phase_o(phase), .cnt_o(cnt),
    .start_nxt_o(start_nxt), .dead_nxt_o(dead_nxt)
  );

  zvs_upper_steer #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_up (
    .clk(clk), .rst_n(rst_n), .clr(fault),
    .phase_i(phase), .cnt_i(cnt), .dead_len(dead_len),
    .start_nxt_i(start_nxt), .dead_nxt_i(dead_nxt),
    .frac_i(resdel_frac), .ul_o(ul), .rdel_nz_o(rdel_nz)
  );

  zvs_lower_mod #(.CNT_W(CNT_W), .LEB_CYC(LEB_CYC), .ZERO_CODE(ZERO_CODE)) u_lo (
    .clk(clk), .rst_n(rst_n), .clr(fault),
    .phase_i(phase), .cnt_i(cnt), .start_nxt_i(start_nxt),
    .duty_i(duty_code), .ovc_i(ovc_flag),
    .ll_o(ll_raw), .lr_o(lr_raw)
  );

  assign out_ul = ul && !fault;
  assign out_ur = !ul && !fault;
  assign out_ll = ll_raw && !fault;
  assign out_lr = lr_raw && !fault;

  // R5
  upper_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ul != $past(ul)) && $past(rdel_nz) |-> !(ll_raw || lr_raw));
  // R9
  fault_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fault) |-> !(out_ll || out_lr));
endmodule

// File: tb/tb_zvs_bridge_pwm.sv
`timescale 1ns/1ps
module tb_zvs_bridge_pwm;
  localparam int LEB = 7;
  localparam int ZC  = 4;
  localparam int BIG = 1 << 30;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic [7:0] chg_len, dead_len, duty_code;
  logic [4:0] resdel_frac;
  logic       ovc_flag, fault;
  logic       out_ul, out_ur, out_ll, out_lr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  zvs_bridge_pwm dut (
    .clk(clk), .rst_n(rst_n), .chg_len(chg_len), .dead_len(dead_len),
    .duty_code(duty_code), .resdel_frac(resdel_frac),
    .ovc_flag(ovc_flag), .fault(fault),
    .out_ul(out_ul), .out_ur(out_ur), .out_ll(out_ll), .out_lr(out_lr)
  );

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp, int t);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: ul/ur/ll/lr actual %b expected %b", tag, t, act, exp);
    end
  endtask

  task automatic run_case(string tag, int c, int d, int duty0, int duty1,
                          int frac0, int frac1, int chg_t, int oj, int olen,
                          int f_t, int f_len, int ncyc);
    int  tr, w_cur, f_cur, tgt_cur, prev_duty, prev_frac;
    bit  ul_m, killed;
    tr = 0; w_cur = 0; f_cur = 0; ul_m = 1'b0; killed = 1'b0;
    rst_n = 1'b0; chg_len = 8'(c); dead_len = 8'(d);
    duty_code = 8'(duty0); resdel_frac = 5'(frac0);
    ovc_flag = 1'b0; fault = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    tgt_cur = d; prev_duty = duty0; prev_frac = frac0;
    for (int t = 0; t < ncyc; t++) begin
      int dv;
      int fv;
      bit fl;
      bit ov;
      logic [3:0] ex;
      dv = (t >= chg_t) ? duty1 : duty0;
      fv = (t >= chg_t) ? frac1 : frac0;
      fl = (t >= f_t) && (t < f_t + f_len);
      ov = 1'b0;
      ex = 4'b0000;
      if (!fl) begin
        if (tr >= d) begin
          int k;
          int p;
          k = (tr - d) / (c + d);
          p = (tr - d) % (c + d);
          if (p == 0) begin
            if (tgt_cur == d) ul_m = ~ul_m;
            w_cur   = (prev_duty > ZC) ? prev_duty - ZC : 0;
            f_cur   = (prev_frac > 16) ? 16 : prev_frac;
            tgt_cur = d - (d * f_cur) / 16;
            killed  = 1'b0;
          end else if (tgt_cur < d && p == c + tgt_cur) begin
            ul_m = ~ul_m;
          end
          if (p < c) begin
            ov = (p >= oj) && (p < oj + olen);
            if (!killed && p < w_cur) begin
              if (ov && p >= LEB) killed = 1'b1;
              else if (k % 2 == 0) ex[0] = 1'b1;
              else ex[1] = 1'b1;
            end
          end
        end
        ex[3] = ul_m;
        ex[2] = ~ul_m;
      end
      duty_code   = 8'(dv);
      resdel_frac = 5'(fv);
      ovc_flag    = ov;
      fault       = fl;
      #1;
      chk(tag, {out_ul, out_ur, out_ll, out_lr}, ex, t);
      prev_duty = dv;
      prev_frac = fv;
      if (fl) begin
        tr = 0; w_cur = 0; f_cur = 0; tgt_cur = d; ul_m = 1'b0; killed = 1'b0;
      end else begin
        tr++;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0; chg_len = 8'd8; dead_len = 8'd4; duty_code = 8'd12;
    resdel_frac = 5'd8; ovc_flag = 1'b0; fault = 1'b0;
    @(negedge clk); @(negedge clk);
    // R1: reset state of the bridge
    chk("R1 reset state", {out_ul, out_ur, out_ll, out_lr}, 4'b0100, 0);
    // R2 R3: duty sweep across the zero level and beyond the charge length
    for (int dc = 0; dc <= 14; dc++)
      run_case("R2 R3 duty sweep", 8, 4, dc, dc, 8, 8, BIG, 0, 0, BIG, 0, 4 + 4 * 12);
    // R4 R5: fraction sweep including 100% and clamped codes
    for (int fr = 0; fr <= 17; fr++)
      run_case("R4 R5 resonant delay", 6, 5, 7, 7, fr, fr, BIG, 0, 0, BIG, 0, 5 + 4 * 11);
    // R6 R7 R8: one-cycle overcurrent at every charge cycle
    for (int j = 0; j < 12; j++)
      run_case("R6 R7 R8 overcurrent", 12, 3, 20, 20, 4, 4, BIG, j, 1, BIG, 0, 3 + 4 * 15);
    // R6 R8: overcurrent held through every charge phase
    run_case("R6 R8 overcurrent held", 12, 3, 20, 20, 4, 4, BIG, 0, 100, BIG, 0, 3 + 4 * 15);
    // R3 R8: zero-duty with upper pair still toggling
    run_case("R3 R8 zero duty", 5, 3, 2, 2, 16, 16, BIG, 0, 0, BIG, 0, 3 + 5 * 8);
    // R10: mid-period change of duty and fraction
    run_case("R10 sampling", 8, 4, 14, 10, 4, 12, 6, 0, 0, BIG, 0, 4 + 4 * 12);
    // R9: fault in the middle of a pulse, then restart
    run_case("R9 fault", 8, 4, 12, 12, 8, 8, BIG, 0, 0, 7, 4, 70);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule